// File: doc/BRIEF.md
# DES / Triple-DES Key and Context Register Front End

This block is the host-side register front end of a block-cipher execution unit that performs DES and Triple DES. A host writes keys, a key-size value and a chaining vector over a simple request/write bus. It streams 64-bit data words into an input queue and collects results from an output queue. A separate cipher core, which is not part of this block, sees the keys, the chaining vector and the selected cipher mode on parallel ports. It pulls words from the input queue, pushes results into the output queue and reports when it is busy.

The three key registers cannot be read back. A write to key slot 1 also loads key slot 3, so two-key Triple DES needs only two key writes. Illegal accesses and queue misuse set sticky status bits. A single interrupt line is raised from the enabled status bits. The whole upper half of the address space is a data window: any address in it pushes to the input queue on a write and pops the output queue on a read.

Top module: `des_keyctx_regif`

Word addresses: 0x00 key 1, 0x01 key 2, 0x02 key 3, 0x03 key size, 0x04 chaining vector, 0x05 status (write 1 to clear), 0x06 interrupt enable. Any address 0x10 to 0x1F is the data window. Status bits: bit 0 key read, bit 1 vector read while busy, bit 2 input overflow, bit 3 output underflow, bit 4 bad key size. `mode_o` encoding: 0 single DES, 1 two-key 3DES, 2 three-key 3DES. Read data appears on `rdata_o` with `rvalid_o` one cycle after the read request.

## Requirements
- R1: In single-DES mode (`mode_o`=0), writes to key 2 (0x01) and key 3 (0x02) leave `key2_o` and `key3_o` unchanged.
- R2: A write to key 1 (0x00) loads the written value into both `key1_o` and `key3_o` on the next cycle.
- R3: Writing 16 to the key-size register (0x03) selects two-key 3DES (`mode_o`=1) with key 3 equal to key 1. Writing 24 selects three-key 3DES (`mode_o`=2), and in that mode a key 3 write placed after key 1 overrides the mirrored value. Writing 8 selects single DES, which is also the reset value.
- R4: A read of any key address returns zero and sets status bit 0.
- R5: The chaining vector (0x04) reads back the value last written. After each block the core processes, it holds the vector the core supplies.
- R6: A read of 0x04 while `busy_i` is high returns zero and sets status bit 1.
- R7: A write to any address 0x10 to 0x1F pushes one word into the 8-entry input queue. A read from any address in that window pops one word from the output queue, in arrival order.
- R8: A write to the full input queue sets status bit 2 and discards the word. A read from the empty output queue returns zero and sets status bit 3.
- R9: Status bits stay set until the host writes 1 to them at 0x05. `irq_o` is high exactly when a status bit is set and its bit in the enable register (0x06) is set.
- R10: A key-size write of any value other than 8, 16 or 24 sets status bit 4 and leaves `mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 5 | Host word address |
| wdata_i | input | 64 | Host write data |
| rdata_o | output | 64 | Host read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Interrupt, OR of enabled status bits |
| key1_o | output | 64 | Key 1 to the core |
| key2_o | output | 64 | Key 2 to the core |
| key3_o | output | 64 | Key 3 to the core |
| iv_o | output | 64 | Chaining vector to the core |
| mode_o | output | 2 | Cipher mode to the core |
| busy_i | input | 1 | Core is processing |
| in_valid_o | output | 1 | Input queue holds a word |
| in_data_o | output | 64 | Head word of the input queue |
| in_ready_i | input | 1 | Core takes the head word |
| out_valid_i | input | 1 | Core delivers a result |
| out_data_i | input | 64 | Result word |
| out_ready_o | output | 1 | Output queue has room |
| iv_upd_i | input | 1 | Core updates the chaining vector |
| iv_nxt_i | input | 64 | New chaining vector |

## Verification
The hardest state to reach is input-queue overflow. It needs both queues full at once, because a live core drains the input queue into the output queue as fast as the host writes. The stub core has a bench-controlled enable. With the stub halted, eight writes fill the input queue and a ninth overflows it. The stub is then released, and the chained results are drained and checked in order against a scoreboard. One further read then hits an empty output queue.

// File: rtl/des_regif_pkg.sv
package des_regif_pkg;
  localparam int ADDR_W = 5;
  localparam int NSTS   = 5;

  localparam logic [ADDR_W-1:0] A_KEY1 = 5'h00;
  localparam logic [ADDR_W-1:0] A_KEY2 = 5'h01;
  localparam logic [ADDR_W-1:0] A_KEY3 = 5'h02;
  localparam logic [ADDR_W-1:0] A_KSZ  = 5'h03;
  localparam logic [ADDR_W-1:0] A_IV   = 5'h04;
  localparam logic [ADDR_W-1:0] A_STS  = 5'h05;
  localparam logic [ADDR_W-1:0] A_IEN  = 5'h06;

  localparam int S_KEYRD = 0;
  localparam int S_IVBSY = 1;
  localparam int S_OVF   = 2;
  localparam int S_UNF   = 3;
  localparam int S_KSZ   = 4;

  typedef enum logic [1:0] {
    MODE_SDES  = 2'd0,
    MODE_TDES2 = 2'd1,
    MODE_TDES3 = 2'd2
  } cmode_e;
endpackage

// File: rtl/des_key_bank.sv
module des_key_bank
  import des_regif_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  cmode_e        mode_i,
  output logic [DW-1:0] key1_o,
  output logic [DW-1:0] key2_o,
  output logic [DW-1:0] key3_o
);
  logic multi_key;
  assign multi_key = (mode_i != MODE_SDES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key1_o <= '0;
      key2_o <= '0;
      key3_o <= '0;
    end else if (wr_i) begin
      if (sel_i[0]) begin
        key1_o <= wdata_i;
        key3_o <= wdata_i;  // mirror for 2-key 3DES
      end else if (sel_i[2] && multi_key) begin
        key3_o <= wdata_i;
      end
      if (sel_i[1] && multi_key) key2_o <= wdata_i;
    end
  end

  a_r1_key2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i[1] && mode_i == MODE_SDES) |=> $stable(key2_o));
  a_r2_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i[0]) |=> (key3_o == key1_o));
endmodule

// File: rtl/des_word_fifo.sv
module des_word_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wptr, rptr;
  logic [PW:0]   count;
  logic          do_push, do_pop;

  assign count   = wptr - rptr;
  assign full_o  = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);
  assign empty_o = (wptr == rptr);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem[rptr[PW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr[PW-1:0]] <= wdata_i;
  end

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= DEPTH[PW:0]);
  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(wptr));
endmodule

// File: rtl/des_irq_ctrl.sv
module des_irq_ctrl #(
  parameter int NB = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic          clr_wr_i,
  input  logic [NB-1:0] clr_mask_i,
  input  logic          en_wr_i,
  input  logic [NB-1:0] en_data_i,
  output logic [NB-1:0] sts_o,
  output logic [NB-1:0] en_o,
  output logic          irq_o
);
  logic [NB-1:0] clr;
  assign clr = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_o <= '0;
      en_o  <= '0;
    end else begin
      sts_o <= (sts_o & ~clr) | set_i;  // set wins over clear
      if (en_wr_i) en_o <= en_data_i;
    end
  end

  assign irq_o = |(sts_o & en_o);

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_o & $past(set_i)) == $past(set_i)));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr_i && set_i == '0) |=> ((sts_o & $past(sts_o)) == $past(sts_o)));
endmodule

// File: rtl/des_keyctx_regif.sv
module des_keyctx_regif
  import des_regif_pkg::*;
#(
  parameter int DW         = 64,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              irq_o,
  output logic [DW-1:0]     key1_o,
  output logic [DW-1:0]     key2_o,
  output logic [DW-1:0]     key3_o,
  output logic [DW-1:0]     iv_o,
  output logic [1:0]        mode_o,
  input  logic              busy_i,
  output logic              in_valid_o,
  output logic [DW-1:0]     in_data_o,
  input  logic              in_ready_i,
  input  logic              out_valid_i,
  input  logic [DW-1:0]     out_data_i,
  output logic              out_ready_o,
  input  logic              iv_upd_i,
  input  logic [DW-1:0]     iv_nxt_i
);
  logic wr, rd, win, key_addr;
  logic [2:0] key_sel;
  cmode_e mode_q;
  logic ksz_ok, ksz_wr;
  cmode_e ksz_mode;
  logic in_full, in_empty, out_full, out_empty;
  logic [DW-1:0] out_head;
  logic [NSTS-1:0] sts_set, sts, ien;
  logic [DW-1:0] rd_mux;

  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;
  assign win = addr_i[ADDR_W-1];
  assign key_addr = !win && (addr_i == A_KEY1 || addr_i == A_KEY2 || addr_i == A_KEY3);
  assign key_sel  = win ? 3'b000 : {addr_i == A_KEY3, addr_i == A_KEY2, addr_i == A_KEY1};

  des_key_bank #(.DW(DW)) u_keys (
    .clk_i, .rst_ni, .wr_i(wr), .sel_i(key_sel), .wdata_i, .mode_i(mode_q),
    .key1_o, .key2_o, .key3_o
  );

  // key-size decode
  assign ksz_wr = wr && !win && addr_i == A_KSZ;
  always_comb begin
    ksz_ok   = 1'b1;
    ksz_mode = MODE_SDES;
    case (wdata_i)
      DW'(8):  ksz_mode = MODE_SDES;
      DW'(16): ksz_mode = MODE_TDES2;
      DW'(24): ksz_mode = MODE_TDES3;
      default: ksz_ok   = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mode_q <= MODE_SDES;
    else if (ksz_wr && ksz_ok)  mode_q <= ksz_mode;
  end
  assign mode_o = mode_q;

  // chaining vector: host write has priority over core update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             iv_o <= '0;
    else if (wr && !win && addr_i == A_IV)   iv_o <= wdata_i;
    else if (iv_upd_i)                       iv_o <= iv_nxt_i;
  end

  des_word_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk_i, .rst_ni, .push_i(wr && win), .wdata_i, .pop_i(in_ready_i),
    .rdata_o(in_data_o), .full_o(in_full), .empty_o(in_empty)
  );
  assign in_valid_o = !in_empty;

  des_word_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk_i, .rst_ni, .push_i(out_valid_i), .wdata_i(out_data_i), .pop_i(rd && win),
    .rdata_o(out_head), .full_o(out_full), .empty_o(out_empty)
  );
  assign out_ready_o = !out_full;

  always_comb begin
    sts_set          = '0;
    sts_set[S_KEYRD] = rd && key_addr;
    sts_set[S_IVBSY] = rd && !win && addr_i == A_IV && busy_i;
    sts_set[S_OVF]   = wr && win && in_full;
    sts_set[S_UNF]   = rd && win && out_empty;
    sts_set[S_KSZ]   = ksz_wr && !ksz_ok;
  end

  des_irq_ctrl #(.NB(NSTS)) u_irq (
    .clk_i, .rst_ni, .set_i(sts_set),
    .clr_wr_i(wr && !win && addr_i == A_STS), .clr_mask_i(wdata_i[NSTS-1:0]),
    .en_wr_i(wr && !win && addr_i == A_IEN), .en_data_i(wdata_i[NSTS-1:0]),
    .sts_o(sts), .en_o(ien), .irq_o
  );

  always_comb begin
    rd_mux = '0;
    if (win) rd_mux = out_head;  // zero when empty
    else begin
      case (addr_i)
        A_KSZ: rd_mux = (mode_q == MODE_TDES3) ? DW'(24) :
                        (mode_q == MODE_TDES2) ? DW'(16) : DW'(8);
        A_IV:  rd_mux = busy_i ? '0 : iv_o;
        A_STS: rd_mux = DW'(sts);
        A_IEN: rd_mux = DW'(ien);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  a_r4_key_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && key_addr) |=> (sts[S_KEYRD] && rdata_o == '0));
  a_r6_iv_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !win && addr_i == A_IV && busy_i) |=> (sts[S_IVBSY] && rdata_o == '0));
  a_r8_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && win && in_full) |=> sts[S_OVF]);
  a_r10_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ksz_wr && !ksz_ok) |=> ($stable(mode_o) && sts[S_KSZ]));
endmodule

// File: tb/des_keyctx_regif_tb.sv
`timescale 1ns/1ps
module des_keyctx_regif_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata, key1, key2, key3, iv, in_data, out_data, iv_nxt;
  logic        rvalid, irq, in_valid, in_ready, out_valid, out_ready, iv_upd;
  logic [1:0]  mode;
  logic        busy = 1'b0, core_en = 1'b0;

  int checks = 0, errors = 0;
  logic [63:0] sb_q[$];
  logic [63:0] m_iv = '0, m_key3 = '0;
  logic        pop_pend = 1'b0;

  always #2.5 clk = ~clk;

  des_keyctx_regif u_dut (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq),
    .key1_o(key1), .key2_o(key2), .key3_o(key3), .iv_o(iv), .mode_o(mode),
    .busy_i(busy), .in_valid_o(in_valid), .in_data_o(in_data), .in_ready_i(in_ready),
    .out_valid_i(out_valid), .out_data_i(out_data), .out_ready_o(out_ready),
    .iv_upd_i(iv_upd), .iv_nxt_i(iv_nxt)
  );

  // stub core: result = in ^ key3 ^ iv, result becomes next vector
  assign in_ready  = core_en && in_valid && out_ready;
  assign out_valid = in_ready;
  assign out_data  = in_data ^ key3 ^ iv;
  assign iv_upd    = in_ready;
  assign iv_nxt    = out_data;

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [63:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    d = rdata;
  endtask

  // driver: push a data word and its expected result
  task automatic push_word(logic [3:0] off, logic [63:0] d, bit dropped);
    wr({1'b1, off}, d);
    if (!dropped) begin
      m_iv = d ^ m_key3 ^ m_iv;
      sb_q.push_back(m_iv);
    end
  endtask

  task automatic pop_word(logic [3:0] off);
    logic [63:0] d;
    rd({1'b1, off}, d);
  endtask

  // monitor: compare each window read with the scoreboard head
  always @(posedge clk) pop_pend <= req && !we && addr[4];
  always @(negedge clk) begin
    if (rvalid && pop_pend) begin
      if (sb_q.size() > 0) check("R7 queue order", rdata, sb_q.pop_front());
      else                 check("R8 empty read data", rdata, 64'h0);
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("reset irq", {63'h0, irq}, 64'h0);
    check("reset in_valid", {63'h0, in_valid}, 64'h0);
    check("R3 reset mode", {62'h0, mode}, 64'h0);
    rd(5'h03, d); check("R3 reset key size", d, 64'd8);
    rd(5'h05, d); check("reset status", d, 64'h0);

    // R2 / R1
    wr(5'h00, 64'hA1A1_0000_0000_0001);
    check("R2 key1", key1, 64'hA1A1_0000_0000_0001);
    check("R2 key3 mirror", key3, 64'hA1A1_0000_0000_0001);
    wr(5'h01, 64'hB2B2);
    check("R1 key2 ignored", key2, 64'h0);
    wr(5'h02, 64'hC3C3);
    check("R1 key3 ignored", key3, 64'hA1A1_0000_0000_0001);

    // R10 / R9
    wr(5'h03, 64'd12);
    check("R10 mode kept", {62'h0, mode}, 64'h0);
    rd(5'h05, d); check("R10 status bit4", d, 64'h10);
    wr(5'h05, 64'h10);
    rd(5'h05, d); check("R9 w1c clears", d, 64'h0);

    // R3
    wr(5'h03, 64'd16);
    check("R3 2-key mode", {62'h0, mode}, 64'h1);
    wr(5'h01, 64'hB2B2);
    check("R3 key2 accepted", key2, 64'hB2B2);
    check("R3 key3 mirrors key1", key3, 64'hA1A1_0000_0000_0001);
    wr(5'h03, 64'd24);
    check("R3 3-key mode", {62'h0, mode}, 64'h2);
    wr(5'h00, 64'hD4); wr(5'h01, 64'hE5); wr(5'h02, 64'hF6);
    check("R3 key1", key1, 64'hD4);
    check("R3 key2", key2, 64'hE5);
    check("R3 key3 override", key3, 64'hF6);
    m_key3 = 64'hF6;

    // R4 / R9
    rd(5'h01, d); check("R4 key read zero", d, 64'h0);
    rd(5'h05, d); check("R4 status bit0", d, 64'h1);
    check("R9 irq masked", {63'h0, irq}, 64'h0);
    wr(5'h06, 64'h1);
    check("R9 irq enabled", {63'h0, irq}, 64'h1);
    wr(5'h05, 64'h1);
    check("R9 irq cleared", {63'h0, irq}, 64'h0);

    // R5 / R6
    wr(5'h04, 64'h0123_4567_89AB_CDEF); m_iv = 64'h0123_4567_89AB_CDEF;
    rd(5'h04, d); check("R5 iv readback", d, 64'h0123_4567_89AB_CDEF);
    busy = 1'b1;
    rd(5'h04, d); check("R6 busy read zero", d, 64'h0);
    busy = 1'b0;
    rd(5'h05, d); check("R6 status bit1", d, 64'h2);
    wr(5'h05, 64'h1F);

    // R7: stream through stub core, various window addresses
    core_en = 1'b1;
    push_word(4'h0, 64'h1111, 0);
    push_word(4'h3, 64'h2222_0000, 0);
    push_word(4'hF, 64'h3333_3333_3333_3333, 0);
    push_word(4'h8, 64'h4, 0);
    push_word(4'h5, 64'hFFFF_0000_FFFF_0000, 0);
    repeat (4) @(negedge clk);
    pop_word(4'h0); pop_word(4'h7); pop_word(4'hF); pop_word(4'h1); pop_word(4'hA);
    rd(5'h04, d); check("R5 iv tracks chain", d, m_iv);
    rd(5'h05, d); check("R7 no errors", d, 64'h0);

    // R8: fill input queue with core halted, then overflow
    core_en = 1'b0;
    for (int i = 0; i < 8; i++) push_word(4'(i), 64'h100 + 64'(i), 0);
    rd(5'h05, d); check("R8 full no overflow", d, 64'h0);
    check("R7 in_valid", {63'h0, in_valid}, 64'h1);
    push_word(4'h9, 64'hDEAD, 1);
    rd(5'h05, d); check("R8 overflow bit2", d, 64'h4);
    wr(5'h05, 64'h4);
    core_en = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 8; i++) pop_word(4'(15 - i));
    pop_word(4'h2);
    rd(5'h05, d); check("R8 underflow bit3", d, 64'h8);
    check("R8 scoreboard drained", 64'(sb_q.size()), 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule